// File: doc/BRIEF.md
# Bus-Mastering Thermal Sensor Sequencer

This block reads up to four on-die temperature sensing points through a converter that lives elsewhere on the chip. It has no converter of its own. It reaches the converter and the analog sensor selector only as a bus master, over a simple valid/ready request channel and a response channel. Software fills a word-addressed register file with five target addresses, the data words for the select and enable writes, one selector code per point, the position and polarity of the converter's ready flag, a right shift and a mask of active points.

A pacing counter starts a sweep at a fixed period. For each active point, in ascending order, the sequencer does the following. It writes the point's selector code, writes the channel select and writes the enable word. It then reads the flag location until the flag shows a finished conversion, and reads the voltage location as well if software asked for a separate read. The sample is shifted, cut to twelve bits and stored in that point's result word, which carries a fresh-data flag. Polling that runs past the programmed limit sets a sticky error and skips the point.

Top module: `thm_seq_top`

## Requirements
- R1: After reset no request is issued, `err_flag` is 0, and every result word (indices 20 to 23) reads as 0.
- R2: For each visited point the request order is: a write of that point's code (indices 16 to 19, zero-extended) to the sensor-select address (index 5), a write of the channel word (index 9) to the channel-select address (index 4), a write of the enable word (index 10) to the enable address (index 6), and then reads of the flag address (index 7). Every request holds its address while it waits for ready.
- R3: Write-control word (index 11): bit 0 allows the sensor-select write and bit 1 allows the channel-select write. A write whose bit is clear is not issued. The enable write is always issued.
- R4: Flag-format word (index 12): bits 4:0 give the flag's bit position in the read data. Bit 5 set means the flag is active high and bit 5 clear means active low. Reads are repeated until the flag is in its active state.
- R5: Read-split word (index 13) bit 0: when it is 0 the sample comes from the flag read itself and no voltage read is issued. When it is 1, one read of the voltage address (index 8) follows the successful flag read and supplies the sample.
- R6: The stored value is the low 12 bits of the sample data shifted right by the shift word (index 14, bits 4:0).
- R7: Only points whose bit is set in the mask word (index 15, bits 3:0) are visited, in ascending index order. Each visited point uses its own code.
- R8: With poll interval P (index 2, bits 15:0), and with a target that holds ready high and answers in the cycle after acceptance, consecutive flag reads are accepted exactly P+3 clock cycles apart.
- R9: The limit word (index 3) counts clocks from the enable-write response. An inactive flag read that arrives once that count has reached the limit sets `err_flag`, which also reads as bit 0 of index 24. The point then gets no new result and the sweep goes on with the next point. Writing 1 to bit 0 of index 24 clears the flag.
- R10: A result word reads the value in bits 11:0 and a fresh-data flag in bit 16. The flag is set when a value is stored and cleared by a read of that word.
- R11: With N in index 0 (bits 9:0) and sweep interval S in index 1 (bits 9:0), sweeps start every `UNIT_CLKS`×N×S clocks. When N or S is zero, no sweep starts.
- R12: At most one bus transaction is in flight: no request is raised between an accepted request and its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (clears fresh-data flags) |
| cfg_addr | input | 5 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| m_req_valid | output | 1 | Bus request valid |
| m_req_ready | input | 1 | Bus request accepted |
| m_req_write | output | 1 | 1 = write, 0 = read |
| m_req_addr | output | 32 | Bus target address |
| m_req_wdata | output | 32 | Bus write data |
| m_rsp_valid | input | 1 | Bus response strobe |
| m_rsp_rdata | input | 32 | Bus read data |
| err_flag | output | 1 | Sticky polling-timeout error |

## Verification
The bench builds the block with `UNIT_CLKS` set to 4 instead of 256. At that value a whole sweep period of a few tens of clocks can be measured exactly between request timestamps. One-unit periods also let each directed sweep start within a handful of cycles. The small poll intervals and limits place the timeout path and the P+3 polling spacing within short runs. A behavioural converter that alternates ready stalls shows that requests hold steady while they wait.

// File: rtl/thm_pkg.sv
package thm_pkg;
    localparam int DW     = 32;
    localparam int NPTS   = 4;
    localparam int RES_W  = 12;
    localparam int CODE_W = 8;
    localparam int RA_W   = 5;
    localparam int PIDX_W = (NPTS > 1) ? $clog2(NPTS) : 1;
    localparam int UPD_BIT = 16;

    // register word indices
    localparam logic [RA_W-1:0] RG_UNIT    = 5'd0;
    localparam logic [RA_W-1:0] RG_SWEEP   = 5'd1;
    localparam logic [RA_W-1:0] RG_POLL    = 5'd2;
    localparam logic [RA_W-1:0] RG_LIMIT   = 5'd3;
    localparam logic [RA_W-1:0] RG_A_CHSEL = 5'd4;
    localparam logic [RA_W-1:0] RG_A_SNSEL = 5'd5;
    localparam logic [RA_W-1:0] RG_A_EN    = 5'd6;
    localparam logic [RA_W-1:0] RG_A_FLAG  = 5'd7;
    localparam logic [RA_W-1:0] RG_A_VOLT  = 5'd8;
    localparam logic [RA_W-1:0] RG_D_CHSEL = 5'd9;
    localparam logic [RA_W-1:0] RG_D_EN    = 5'd10;
    localparam logic [RA_W-1:0] RG_WRCTL   = 5'd11;
    localparam logic [RA_W-1:0] RG_FLAGFMT = 5'd12;
    localparam logic [RA_W-1:0] RG_SPLIT   = 5'd13;
    localparam logic [RA_W-1:0] RG_SHIFT   = 5'd14;
    localparam logic [RA_W-1:0] RG_MASK    = 5'd15;
    localparam logic [RA_W-1:0] RG_CODE0   = 5'd16;
    localparam logic [RA_W-1:0] RG_RES0    = 5'd20;
    localparam logic [RA_W-1:0] RG_STAT    = 5'd24;

    typedef enum logic [2:0] {OP_SNSEL, OP_CHSEL, OP_EN, OP_FLAG, OP_VOLT} op_e;

    typedef struct packed {
        logic [9:0]                   unit_n;
        logic [9:0]                   sweep_ivl;
        logic [15:0]                  poll_ivl;
        logic [DW-1:0]                limit;
        logic [DW-1:0]                a_chsel;
        logic [DW-1:0]                a_snsel;
        logic [DW-1:0]                a_en;
        logic [DW-1:0]                a_flag;
        logic [DW-1:0]                a_volt;
        logic [DW-1:0]                d_chsel;
        logic [DW-1:0]                d_en;
        logic [1:0]                   wr_ctl;
        logic [4:0]                   flag_pos;
        logic                         flag_high;
        logic                         split;
        logic [4:0]                   shift;
        logic [NPTS-1:0]              mask;
        logic [NPTS-1:0][CODE_W-1:0]  code;
    } cfg_t;

    function automatic op_e first_op(input logic [1:0] wc);
        if (wc[0])      return OP_SNSEL;
        else if (wc[1]) return OP_CHSEL;
        else            return OP_EN;
    endfunction

    function automatic logic [PIDX_W-1:0] low_idx(input logic [NPTS-1:0] m);
        logic [PIDX_W-1:0] r;
        r = '0;
        for (int i = NPTS - 1; i >= 0; i--)
            if (m[i]) r = PIDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/thm_regs.sv
module thm_regs
    import thm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic                  cfg_re,
    input  logic [RA_W-1:0]       cfg_addr,
    input  logic [DW-1:0]         cfg_wdata,
    output logic [DW-1:0]         cfg_rdata,
    input  logic                  res_we,
    input  logic [PIDX_W-1:0]     res_idx,
    input  logic [RES_W-1:0]      res_data,
    input  logic                  err_set,
    output cfg_t                  cfg,
    output logic [NPTS-1:0]       upd,
    output logic                  err
);
    logic [NPTS-1:0][RES_W-1:0] res;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                RG_UNIT:    cfg.unit_n    <= cfg_wdata[9:0];
                RG_SWEEP:   cfg.sweep_ivl <= cfg_wdata[9:0];
                RG_POLL:    cfg.poll_ivl  <= cfg_wdata[15:0];
                RG_LIMIT:   cfg.limit     <= cfg_wdata;
                RG_A_CHSEL: cfg.a_chsel   <= cfg_wdata;
                RG_A_SNSEL: cfg.a_snsel   <= cfg_wdata;
                RG_A_EN:    cfg.a_en      <= cfg_wdata;
                RG_A_FLAG:  cfg.a_flag    <= cfg_wdata;
                RG_A_VOLT:  cfg.a_volt    <= cfg_wdata;
                RG_D_CHSEL: cfg.d_chsel   <= cfg_wdata;
                RG_D_EN:    cfg.d_en      <= cfg_wdata;
                RG_WRCTL:   cfg.wr_ctl    <= cfg_wdata[1:0];
                RG_FLAGFMT: begin
                    cfg.flag_pos  <= cfg_wdata[4:0];
                    cfg.flag_high <= cfg_wdata[5];
                end
                RG_SPLIT:   cfg.split     <= cfg_wdata[0];
                RG_SHIFT:   cfg.shift     <= cfg_wdata[4:0];
                RG_MASK:    cfg.mask      <= cfg_wdata[NPTS-1:0];
                default: ;
            endcase
            for (int i = 0; i < NPTS; i++)
                if (cfg_addr == RG_CODE0 + RA_W'(i))
                    cfg.code[i] <= cfg_wdata[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
            upd <= '0;
            err <= 1'b0;
        end else begin
            for (int i = 0; i < NPTS; i++) begin
                if (cfg_re && cfg_addr == RG_RES0 + RA_W'(i))
                    upd[i] <= 1'b0;
                if (res_we && res_idx == PIDX_W'(i)) begin
                    res[i] <= res_data;
                    upd[i] <= 1'b1;
                end
            end
            if (cfg_we && cfg_addr == RG_STAT && cfg_wdata[0])
                err <= 1'b0;
            if (err_set)
                err <= 1'b1;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NPTS; i++) begin
            if (cfg_addr == RG_RES0 + RA_W'(i)) begin
                cfg_rdata[RES_W-1:0] = res[i];
                cfg_rdata[UPD_BIT]   = upd[i];
            end
        end
        if (cfg_addr == RG_STAT)
            cfg_rdata[0] = err;
    end
endmodule

// File: rtl/thm_pace.sv
module thm_pace #(
    parameter int UNIT_CLKS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [9:0] unit_n,
    input  logic [9:0] sweep_ivl,
    output logic       start
);
    localparam int SW = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;

    logic [SW-1:0] sub;
    logic [9:0]    ucnt;
    logic [9:0]    scnt;
    logic          run, sub_end, u_end, s_end;

    always_comb begin
        run     = (unit_n != '0) && (sweep_ivl != '0);
        sub_end = (sub == SW'(UNIT_CLKS - 1));
        u_end   = (ucnt >= unit_n - 10'd1);
        s_end   = (scnt >= sweep_ivl - 10'd1);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sub   <= '0;
            ucnt  <= '0;
            scnt  <= '0;
            start <= 1'b0;
        end else begin
            start <= sub_end && u_end && s_end;
            sub   <= sub_end ? '0 : sub + SW'(1);
            if (sub_end)
                ucnt <= u_end ? '0 : ucnt + 10'd1;
            if (sub_end && u_end)
                scnt <= s_end ? '0 : scnt + 10'd1;
        end
    end
endmodule

// File: rtl/thm_seq.sv
module thm_seq
    import thm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cfg_t              cfg,
    output logic              m_req_valid,
    input  logic              m_req_ready,
    output logic              m_req_write,
    output logic [DW-1:0]     m_req_addr,
    output logic [DW-1:0]     m_req_wdata,
    input  logic              m_rsp_valid,
    input  logic [DW-1:0]     m_rsp_rdata,
    output logic              res_we,
    output logic [PIDX_W-1:0] res_idx,
    output logic [RES_W-1:0]  res_data,
    output logic              err_set
);
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_WAIT} st_e;

    st_e               st;
    op_e               op;
    logic [NPTS-1:0]   rem, rem_nx;
    logic [PIDX_W-1:0] pt;
    logic [15:0]       wcnt;
    logic [DW-1:0]     elapsed, shifted;
    logic              hit, rsp_now, do_store, do_tmo, do_fin;
    logic              unused_fields;

    assign unused_fields = ^{cfg.unit_n, cfg.sweep_ivl};

    always_comb begin
        pt       = low_idx(rem);
        rem_nx   = rem & ~(NPTS'(1) << pt);
        hit      = (m_rsp_rdata[cfg.flag_pos] == cfg.flag_high);
        shifted  = m_rsp_rdata >> cfg.shift;
        rsp_now  = (st == S_RSP) && m_rsp_valid;
        do_store = rsp_now && ((op == OP_FLAG && hit && !cfg.split) || op == OP_VOLT);
        do_tmo   = rsp_now && op == OP_FLAG && !hit && (elapsed >= cfg.limit);
        do_fin   = do_store || do_tmo;
    end

    always_comb begin
        m_req_valid = (st == S_REQ);
        m_req_write = 1'b0;
        m_req_addr  = '0;
        m_req_wdata = '0;
        case (op)
            OP_SNSEL: begin m_req_write = 1'b1; m_req_addr = cfg.a_snsel; m_req_wdata = DW'(cfg.code[pt]); end
            OP_CHSEL: begin m_req_write = 1'b1; m_req_addr = cfg.a_chsel; m_req_wdata = cfg.d_chsel; end
            OP_EN:    begin m_req_write = 1'b1; m_req_addr = cfg.a_en;    m_req_wdata = cfg.d_en; end
            OP_FLAG:  m_req_addr = cfg.a_flag;
            default:  m_req_addr = cfg.a_volt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            op       <= OP_EN;
            rem      <= '0;
            wcnt     <= '0;
            elapsed  <= '0;
            res_we   <= 1'b0;
            res_idx  <= '0;
            res_data <= '0;
            err_set  <= 1'b0;
        end else begin
            res_we   <= do_store;
            err_set  <= do_tmo;
            res_idx  <= pt;
            res_data <= shifted[RES_W-1:0];
            if (op == OP_FLAG && st != S_IDLE && elapsed != '1)
                elapsed <= elapsed + DW'(1);
            case (st)
                S_IDLE: if (start && cfg.mask != '0) begin
                    rem <= cfg.mask;
                    op  <= first_op(cfg.wr_ctl);
                    st  <= S_REQ;
                end
                S_REQ: if (m_req_ready) st <= S_RSP;
                S_RSP: if (m_rsp_valid) begin
                    st <= S_REQ;
                    case (op)
                        OP_SNSEL: op <= cfg.wr_ctl[1] ? OP_CHSEL : OP_EN;
                        OP_CHSEL: op <= OP_EN;
                        OP_EN: begin
                            op      <= OP_FLAG;
                            elapsed <= '0;
                        end
                        OP_FLAG: begin
                            if (hit && cfg.split)
                                op <= OP_VOLT;
                            else if (!hit && !do_tmo) begin
                                st   <= S_WAIT;
                                wcnt <= '0;
                            end
                        end
                        default: ;
                    endcase
                end
                default: begin
                    if (wcnt == cfg.poll_ivl) st <= S_REQ;
                    else                      wcnt <= wcnt + 16'd1;
                end
            endcase
            if (do_fin) begin
                rem <= rem_nx;
                if (rem_nx == '0) st <= S_IDLE;
                else              op <= first_op(cfg.wr_ctl);
            end
        end
    end
endmodule

// File: rtl/thm_seq_top.sv
module thm_seq_top #(
    parameter int UNIT_CLKS = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic                     cfg_re,
    input  logic [thm_pkg::RA_W-1:0] cfg_addr,
    input  logic [thm_pkg::DW-1:0]   cfg_wdata,
    output logic [thm_pkg::DW-1:0]   cfg_rdata,
    output logic                     m_req_valid,
    input  logic                     m_req_ready,
    output logic                     m_req_write,
    output logic [thm_pkg::DW-1:0]   m_req_addr,
    output logic [thm_pkg::DW-1:0]   m_req_wdata,
    input  logic                     m_rsp_valid,
    input  logic [thm_pkg::DW-1:0]   m_rsp_rdata,
    output logic                     err_flag
);
    import thm_pkg::*;

    cfg_t              cfg;
    logic              start;
    logic              res_we;
    logic [PIDX_W-1:0] res_idx;
    logic [RES_W-1:0]  res_data;
    logic              err_set;
    logic [NPTS-1:0]   upd;

    thm_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
        .err_set(err_set), .cfg(cfg), .upd(upd), .err(err_flag)
    );

    thm_pace #(.UNIT_CLKS(UNIT_CLKS)) u_pace (
        .clk(clk), .rst(rst), .unit_n(cfg.unit_n),
        .sweep_ivl(cfg.sweep_ivl), .start(start)
    );

    thm_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
        .m_req_write(m_req_write), .m_req_addr(m_req_addr),
        .m_req_wdata(m_req_wdata), .m_rsp_valid(m_rsp_valid),
        .m_rsp_rdata(m_rsp_rdata), .res_we(res_we), .res_idx(res_idx),
        .res_data(res_data), .err_set(err_set)
    );
endmodule

// File: rtl/thm_seq_chk.sv
module thm_seq_chk
    import thm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              m_req_valid,
    input logic              m_req_ready,
    input logic [DW-1:0]     m_req_addr,
    input logic              m_rsp_valid,
    input logic              err_flag,
    input logic              cfg_we,
    input logic [RA_W-1:0]   cfg_addr,
    input logic              clr_bit,
    input logic              res_we,
    input logic [PIDX_W-1:0] res_idx,
    input logic [NPTS-1:0]   upd,
    input logic [DW-1:0]     a_chsel,
    input logic [DW-1:0]     a_snsel,
    input logic [DW-1:0]     a_en,
    input logic [DW-1:0]     a_flag,
    input logic [DW-1:0]     a_volt
);
    logic in_flight;

    always_ff @(posedge clk) begin
        if (rst)                              in_flight <= 1'b0;
        else if (m_req_valid && m_req_ready)  in_flight <= 1'b1;
        else if (m_rsp_valid)                 in_flight <= 1'b0;
    end

    p_one_in_flight_r12: assert property (@(posedge clk) disable iff (rst)
        in_flight |-> !m_req_valid);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (m_req_valid && !m_req_ready) |=> (m_req_valid && $stable(m_req_addr)));

    p_addr_known_r2: assert property (@(posedge clk) disable iff (rst)
        m_req_valid |-> (m_req_addr == a_chsel || m_req_addr == a_snsel ||
                         m_req_addr == a_en || m_req_addr == a_flag ||
                         m_req_addr == a_volt));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !(cfg_we && cfg_addr == RG_STAT && clr_bit)) |=> err_flag);

    p_fresh_set_r10: assert property (@(posedge clk) disable iff (rst)
        res_we |=> upd[$past(res_idx)]);
endmodule

bind thm_seq_top thm_seq_chk u_chk (
    .clk(clk), .rst(rst), .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
    .m_req_addr(m_req_addr), .m_rsp_valid(m_rsp_valid), .err_flag(err_flag),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .clr_bit(cfg_wdata[0]),
    .res_we(res_we), .res_idx(res_idx), .upd(upd),
    .a_chsel(cfg.a_chsel), .a_snsel(cfg.a_snsel), .a_en(cfg.a_en),
    .a_flag(cfg.a_flag), .a_volt(cfg.a_volt)
);

// File: tb/thm_seq_top_tb.sv
module thm_seq_top_tb;
    import thm_pkg::*;

    localparam logic [31:0] A_CH   = 32'h1000_000C;
    localparam logic [31:0] A_SN   = 32'h2000_0604;
    localparam logic [31:0] A_EN   = 32'h1000_0008;
    localparam logic [31:0] A_FL   = 32'h1000_0040;
    localparam logic [31:0] A_VO   = 32'h1000_0050;
    localparam logic [31:0] D_CH   = 32'h0000_0800;
    localparam logic [31:0] D_EN   = 32'h0000_0801;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_re = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        m_req_valid, m_req_ready, m_req_write;
    logic [31:0] m_req_addr, m_req_wdata;
    logic        m_rsp_valid = 1'b0;
    logic [31:0] m_rsp_rdata = '0;
    logic        err_flag;

    always #2.5 clk = ~clk;

    thm_seq_top #(.UNIT_CLKS(4)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
        .m_req_write(m_req_write), .m_req_addr(m_req_addr),
        .m_req_wdata(m_req_wdata), .m_rsp_valid(m_rsp_valid),
        .m_rsp_rdata(m_rsp_rdata), .err_flag(err_flag)
    );

    // behavioural converter and sensor selector
    int          cyc = 0;
    int          nlog = 0;
    logic        lg_w [64];
    logic [31:0] lg_a [64];
    logic [31:0] lg_d [64];
    int          lg_t [64];
    int          poll_delay = 0;
    int          polls_left = 0;
    logic [7:0]  last_code = '0;
    int          m_pos = 12;
    logic        m_high = 1'b1;
    logic [31:0] volt_word = '0;
    logic        stall = 1'b0;
    logic        rdy_tog = 1'b0;

    assign m_req_ready = !stall || rdy_tog;

    function automatic logic [11:0] samp(input logic [7:0] c);
        return 12'(int'(c) * 37 + 5);
    endfunction

    always @(posedge clk) begin
        logic [31:0] w;
        cyc     = cyc + 1;
        rdy_tog <= ~rdy_tog;
        m_rsp_valid <= 1'b0;
        if (m_req_valid && m_req_ready) begin
            if (nlog < 64) begin
                lg_w[nlog] = m_req_write;
                lg_a[nlog] = m_req_addr;
                lg_d[nlog] = m_req_wdata;
                lg_t[nlog] = cyc;
            end
            nlog = nlog + 1;
            m_rsp_valid <= 1'b1;
            w = '0;
            if (m_req_write) begin
                if (m_req_addr == A_SN) last_code = m_req_wdata[7:0];
                if (m_req_addr == A_EN) polls_left = poll_delay;
            end else if (m_req_addr == A_VO) begin
                w = volt_word;
            end else begin
                w = 32'(samp(last_code));
                if (last_code != 8'hEE && polls_left == 0) w[m_pos] = m_high;
                else begin
                    w[m_pos] = !m_high;
                    if (polls_left > 0) polls_left = polls_left - 1;
                end
            end
            m_rsp_rdata <= w;
        end
    end

    int  nchk = 0, nfail = 0;
    bit  done = 1'b0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_re = 1'b1; cfg_addr = a;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_re = 1'b0;
    endtask

    task automatic clear_fresh();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) rd(RG_RES0 + 5'(i), d);
    endtask

    task automatic wait_quiet();
        int idle;
        idle = 0;
        while (idle < 30) begin
            @(negedge clk);
            if (m_req_valid) idle = 0;
            else idle++;
        end
    endtask

    task automatic run_sweep();
        int n;
        nlog = 0;
        wr(RG_SWEEP, 32'd1);
        n = 0;
        while (!m_req_valid && n < 100) begin @(negedge clk); n++; end
        wr(RG_SWEEP, 32'd0);
        wait_quiet();
    endtask

    task automatic base_cfg();
        wr(RG_UNIT, 32'd1);
        wr(RG_A_CHSEL, A_CH);
        wr(RG_A_SNSEL, A_SN);
        wr(RG_A_EN, A_EN);
        wr(RG_A_FLAG, A_FL);
        wr(RG_A_VOLT, A_FL);
        wr(RG_D_CHSEL, D_CH);
        wr(RG_D_EN, D_EN);
        wr(RG_FLAGFMT, 32'h2C);
        wr(RG_SPLIT, 32'd0);
        wr(RG_SHIFT, 32'd0);
        wr(RG_LIMIT, 32'hFFFF_FFFF);
        wr(RG_POLL, 32'd1);
        m_pos = 12; m_high = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 req_valid after reset", 32'(m_req_valid), 0);
        chk("R1 err after reset", 32'(err_flag), 0);
        for (int i = 0; i < 4; i++) begin
            rd(RG_RES0 + 5'(i), d);
            chk("R1 result word after reset", d, 0);
        end
    endtask

    task automatic t_basic();
        logic [31:0] d;
        base_cfg();
        wr(RG_WRCTL, 32'd3);
        wr(RG_MASK, 32'b0001);
        wr(RG_CODE0, 32'h11);
        poll_delay = 2;
        run_sweep();
        chk("R2 request count", 32'(nlog), 6);
        chk("R2 req0 addr", lg_a[0], A_SN);
        chk("R2 req0 data", lg_d[0], 32'h11);
        chk("R2 req1 addr", lg_a[1], A_CH);
        chk("R2 req1 data", lg_d[1], D_CH);
        chk("R2 req2 addr", lg_a[2], A_EN);
        chk("R2 req2 data", lg_d[2], D_EN);
        for (int i = 3; i < 6; i++) begin
            chk("R2 flag read addr", lg_a[i], A_FL);
            chk("R2 flag read is read", 32'(lg_w[i]), 0);
        end
        for (int i = 1; i < 6; i++)
            chk("R12 accept spacing >= 2", 32'(lg_t[i] - lg_t[i-1] >= 2), 1);
        rd(RG_RES0, d);
        chk("R4 R10 result with fresh flag", d, 32'h1_0000 | 32'(samp(8'h11)));
        rd(RG_RES0, d);
        chk("R10 fresh flag cleared by read", d, 32'(samp(8'h11)));
    endtask

    task automatic t_gate();
        base_cfg();
        wr(RG_MASK, 32'b0001);
        poll_delay = 0;
        stall = 1'b1;
        wr(RG_WRCTL, 32'd2);
        run_sweep();
        chk("R3 chsel-only count", 32'(nlog), 3);
        chk("R3 chsel-only first", lg_a[0], A_CH);
        chk("R3 chsel-only second", lg_a[1], A_EN);
        wr(RG_WRCTL, 32'd0);
        run_sweep();
        stall = 1'b0;
        chk("R3 no-select count", 32'(nlog), 2);
        chk("R3 no-select first", lg_a[0], A_EN);
        clear_fresh();
    endtask

    task automatic t_order();
        logic [31:0] d;
        base_cfg();
        wr(RG_WRCTL, 32'd1);
        wr(RG_CODE0, 32'h99);
        wr(RG_CODE0 + 5'd1, 32'h21);
        wr(RG_CODE0 + 5'd3, 32'h43);
        wr(RG_MASK, 32'b1010);
        poll_delay = 0;
        run_sweep();
        chk("R7 request count", 32'(nlog), 6);
        chk("R7 first point code", lg_d[0], 32'h21);
        chk("R7 second point select addr", lg_a[3], A_SN);
        chk("R7 second point code", lg_d[3], 32'h43);
        rd(RG_RES0, d);
        chk("R7 skipped point not fresh", d[16], 0);
        rd(RG_RES0 + 5'd1, d);
        chk("R7 point1 result", d, 32'h1_0000 | 32'(samp(8'h21)));
        rd(RG_RES0 + 5'd3, d);
        chk("R7 point3 result", d, 32'h1_0000 | 32'(samp(8'h43)));
    endtask

    task automatic t_polarity();
        logic [31:0] d;
        base_cfg();
        wr(RG_FLAGFMT, 32'd20);
        m_pos = 20; m_high = 1'b0;
        wr(RG_WRCTL, 32'd1);
        wr(RG_MASK, 32'b0001);
        wr(RG_CODE0, 32'h05);
        poll_delay = 1;
        run_sweep();
        chk("R4 active-low request count", 32'(nlog), 4);
        rd(RG_RES0, d);
        chk("R4 active-low result", d, 32'h1_0000 | 32'(samp(8'h05)));
    endtask

    task automatic t_split_shift();
        logic [31:0] d;
        base_cfg();
        wr(RG_A_VOLT, A_VO);
        wr(RG_SPLIT, 32'd1);
        wr(RG_SHIFT, 32'd4);
        wr(RG_WRCTL, 32'd0);
        wr(RG_MASK, 32'b0001);
        volt_word = 32'h0ABC_D5A7;
        poll_delay = 0;
        run_sweep();
        chk("R5 split request count", 32'(nlog), 3);
        chk("R5 voltage read addr", lg_a[2], A_VO);
        chk("R5 voltage read is read", 32'(lg_w[2]), 0);
        rd(RG_RES0, d);
        chk("R6 shifted 12-bit result", d, 32'h1_0D5A);
    endtask

    task automatic t_poll_gap();
        base_cfg();
        wr(RG_POLL, 32'd5);
        wr(RG_WRCTL, 32'd0);
        wr(RG_MASK, 32'b0001);
        poll_delay = 2;
        run_sweep();
        chk("R8 request count", 32'(nlog), 4);
        chk("R8 first poll gap", 32'(lg_t[2] - lg_t[1]), 8);
        chk("R8 second poll gap", 32'(lg_t[3] - lg_t[2]), 8);
        clear_fresh();
    endtask

    task automatic t_timeout();
        logic [31:0] d;
        base_cfg();
        wr(RG_LIMIT, 32'd10);
        wr(RG_POLL, 32'd2);
        wr(RG_WRCTL, 32'd1);
        wr(RG_CODE0, 32'hEE);
        wr(RG_CODE0 + 5'd1, 32'h07);
        wr(RG_MASK, 32'b0011);
        poll_delay = 0;
        chk("R9 err clear before", 32'(err_flag), 0);
        run_sweep();
        chk("R9 err set on timeout", 32'(err_flag), 1);
        rd(RG_RES0, d);
        chk("R9 timed-out point not fresh", d[16], 0);
        rd(RG_RES0 + 5'd1, d);
        chk("R9 next point still served", d, 32'h1_0000 | 32'(samp(8'h07)));
        rd(RG_STAT, d);
        chk("R9 status bit", d, 1);
        wr(RG_STAT, 32'd1);
        chk("R9 err cleared by write", 32'(err_flag), 0);
    endtask

    task automatic t_period();
        int cnt;
        base_cfg();
        wr(RG_WRCTL, 32'd0);
        wr(RG_MASK, 32'b0001);
        wr(RG_UNIT, 32'd2);
        poll_delay = 0;
        nlog = 0;
        wr(RG_SWEEP, 32'd3);
        cnt = 0;
        while (nlog < 6 && cnt < 500) begin @(negedge clk); cnt++; end
        wr(RG_SWEEP, 32'd0);
        wait_quiet();
        chk("R11 first period", 32'(lg_t[2] - lg_t[0]), 24);
        chk("R11 second period", 32'(lg_t[4] - lg_t[2]), 24);
        cnt = nlog;
        repeat (100) @(negedge clk);
        chk("R11 no sweep when interval zero", 32'(nlog), 32'(cnt));
        wr(RG_UNIT, 32'd1);
        clear_fresh();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog (all requirements): act=hung exp=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_gate();
        t_order();
        t_polarity();
        t_split_shift();
        t_poll_gap();
        t_timeout();
        t_period();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule